// File: doc/BRIEF.md
# Microcoded Pixel Point ALU

This block sits at the head of an image pipeline, ahead of the row delay lines. Each clock it takes one 8-bit pixel, optionally passes it through up to three extra pipeline registers, combines it with a held 8-bit operand under control of a 10-bit microcode word, shifts the result, and registers one 8-bit pixel for the next stage.

The microcode word has two independent fields. The low seven bits choose a logic or arithmetic function of the pixel (A) and the held operand (B). The high three bits choose a post-shift of that result. The operand register B captures the coefficient bus on any clock edge where its enable input is high, so a controller can change the brightness offset or mask on the fly. A hold input freezes the pixel path. A frame clear flushes the pixel path between frames and keeps the configuration.

Top module: `pix_point_alu`

## Requirements
- R1: After reset `pix_out` is 0. The microcode is pass A with no shift (0000011000). The input delay is 0, and the B operand is 0.
- R2: `mc_we` high at a clock edge loads `mc_in` into the microcode register. `dly_we` high at a clock edge loads `dly_in` into the delay setting. Both loads act whatever the state of `hold`, and the new values govern results computed from the following edge on.
- R3: Logic functions, selected by microcode bits 6:0, are: 0000000 all zeros, 1111000 all ones, 0011000 A, 0101000 B, 1100000 NOT A, 1010000 NOT B, 0001000 A AND B, 0111000 A OR B, 1110000 A NAND B, 0110000 A XOR B, and 1001000 A XNOR B.
- R4: Arithmetic functions, selected by microcode bits 6:0, are: 0110001 A+B, 1001010 A-B, and 1001100 B-A. Each keeps only the low 8 bits of the result.
- R5: Microcode bits 9:7 shift the function result whatever the function is. The codes are: 000 none, 001/010/011 logical right by 1/2/3, and 100/101/110 left by 1/2/3 with the high bits dropped. Code 111 gives 0.
- R6: Any value of bits 6:0 not listed in R3 or R4 gives 0.
- R7: On an edge with `b_en` high and `hold` low, the B operand takes `cin`. Otherwise it keeps its value.
- R8: With delay setting D (0 to 3), the pixel presented at clock edge k determines `pix_out` after edge k+D. `pix_out` is registered, so the total latency is D+1 edges.
- R9: On an edge with `hold` high and `frame_clr` low, the delay registers, `pix_out` and the B operand keep their values. The pixel presented at that edge is lost.
- R10: On an edge with `frame_clr` high, the delay registers and `pix_out` become 0, even when `hold` is high. The microcode, the delay setting and B are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_clr | input | 1 | Synchronous pixel-path flush between frames |
| hold | input | 1 | Freeze pixel path and B operand for this edge |
| mc_we | input | 1 | Load strobe for the microcode word |
| mc_in | input | 10 | Microcode word: [9:7] shift, [6:0] function |
| dly_we | input | 1 | Load strobe for the input delay setting |
| dly_in | input | 2 | Number of extra input delay registers |
| b_en | input | 1 | Load enable for the B operand |
| cin | input | 8 | Coefficient bus, source of B |
| pix_in | input | 8 | Incoming pixel (operand A before delay) |
| pix_out | output | 8 | Processed pixel toward the row delay lines |

## Verification
With the delay setting at 0, a pixel driven before an edge appears on `pix_out` right after that edge. Each extra delay register adds one edge. A microcode or B load becomes visible in the result computed at the next edge after the load. The bench drives every input on the falling edge and reads `pix_out` on the falling edge after exactly D+1 rising edges. In the delay and hold sequences it tracks how many edges the pixel path has actually advanced, and takes the expected pixel from that count.

// File: rtl/pix_point_alu.sv
module pix_point_alu #(
  parameter int W    = 8,
  parameter int MAXD = 3,
  parameter int MCW  = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_clr,
  input  logic                        hold,
  input  logic                        mc_we,
  input  logic [MCW-1:0]              mc_in,
  input  logic                        dly_we,
  input  logic [$clog2(MAXD+1)-1:0]   dly_in,
  input  logic                        b_en,
  input  logic [W-1:0]                cin,
  input  logic [W-1:0]                pix_in,
  output logic [W-1:0]                pix_out
);
  localparam int DW = $clog2(MAXD+1);
  localparam logic [MCW-1:0] MC_RESET = MCW'(10'b000_0011000);

  localparam logic [6:0] OP_ZERO = 7'b0000000;
  localparam logic [6:0] OP_ONES = 7'b1111000;
  localparam logic [6:0] OP_A    = 7'b0011000;
  localparam logic [6:0] OP_B    = 7'b0101000;
  localparam logic [6:0] OP_NA   = 7'b1100000;
  localparam logic [6:0] OP_NB   = 7'b1010000;
  localparam logic [6:0] OP_ADD  = 7'b0110001;
  localparam logic [6:0] OP_AMB  = 7'b1001010;
  localparam logic [6:0] OP_BMA  = 7'b1001100;
  localparam logic [6:0] OP_AND  = 7'b0001000;
  localparam logic [6:0] OP_OR   = 7'b0111000;
  localparam logic [6:0] OP_NAND = 7'b1110000;
  localparam logic [6:0] OP_XOR  = 7'b0110000;
  localparam logic [6:0] OP_XNOR = 7'b1001000;

  logic [MCW-1:0] mc_q;
  logic [DW-1:0]  dly_q;
  logic [W-1:0]   b_q;
  logic [W-1:0]   dline [MAXD];
  logic [W-1:0]   a_op, fn_res, sh_res;
  logic           step;

  assign step = !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q  <= MC_RESET;
      dly_q <= '0;
    end else begin
      if (mc_we)  mc_q  <= mc_in;
      if (dly_we) dly_q <= dly_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              b_q <= '0;
    else if (step && b_en)   b_q <= cin;
  end

  for (genvar i = 0; i < MAXD; i++) begin : g_dly
    logic [W-1:0] d_src;
    if (i == 0) begin : g_head
      assign d_src = pix_in;
    end else begin : g_tail
      assign d_src = dline[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dline[i] <= '0;
      else if (frame_clr) dline[i] <= '0;
      else if (step)      dline[i] <= d_src;
    end
  end

  always_comb begin
    a_op = pix_in;
    for (int i = 1; i <= MAXD; i++)
      if (dly_q == DW'(i)) a_op = dline[i-1];
  end

  always_comb begin
    case (mc_q[6:0])
      OP_ZERO: fn_res = '0;
      OP_ONES: fn_res = '1;
      OP_A:    fn_res = a_op;
      OP_B:    fn_res = b_q;
      OP_NA:   fn_res = ~a_op;
      OP_NB:   fn_res = ~b_q;
      OP_ADD:  fn_res = a_op + b_q;
      OP_AMB:  fn_res = a_op - b_q;
      OP_BMA:  fn_res = b_q - a_op;
      OP_AND:  fn_res = a_op & b_q;
      OP_OR:   fn_res = a_op | b_q;
      OP_NAND: fn_res = ~(a_op & b_q);
      OP_XOR:  fn_res = a_op ^ b_q;
      OP_XNOR: fn_res = ~(a_op ^ b_q);
      default: fn_res = '0;
    endcase
  end

  always_comb begin
    case (mc_q[9:7])
      3'b000:  sh_res = fn_res;
      3'b001:  sh_res = fn_res >> 1;
      3'b010:  sh_res = fn_res >> 2;
      3'b011:  sh_res = fn_res >> 3;
      3'b100:  sh_res = fn_res << 1;
      3'b101:  sh_res = fn_res << 2;
      3'b110:  sh_res = fn_res << 3;
      default: sh_res = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pix_out <= '0;
    else if (frame_clr) pix_out <= '0;
    else if (step)      pix_out <= sh_res;
  end

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !frame_clr) |=> $stable(pix_out)); // R9
  AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(b_q)); // R9
  AST_FRAME_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clr |=> (pix_out == '0)); // R10
  AST_B_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && !hold) |=> (b_q == $past(cin))); // R7
  AST_B_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !b_en |=> $stable(b_q)); // R7
  AST_PASS_NODELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_q == MC_RESET && dly_q == '0 && !hold && !frame_clr)
      |=> (pix_out == $past(pix_in))); // R8
  AST_ZERO_FN: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_q[6:0] == OP_ZERO && !hold && !frame_clr) |=> (pix_out == '0)); // R3
  AST_BAD_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_q[9:7] == 3'b111 && !hold && !frame_clr) |=> (pix_out == '0)); // R5
endmodule

// File: tb/tb_pix_point_alu.sv
module tb_pix_point_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_clr = 1'b0, hold = 1'b0, mc_we = 1'b0, dly_we = 1'b0, b_en = 1'b0;
  logic [9:0] mc_in = '0;
  logic [1:0] dly_in = '0;
  logic [7:0] cin = '0, pix_in = '0;
  logic [7:0] pix_out;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  pix_point_alu dut (
    .clk(clk), .rst_n(rst_n), .frame_clr(frame_clr), .hold(hold),
    .mc_we(mc_we), .mc_in(mc_in), .dly_we(dly_we), .dly_in(dly_in),
    .b_en(b_en), .cin(cin), .pix_in(pix_in), .pix_out(pix_out)
  );

  function automatic logic [7:0] model(input logic [9:0] mc, input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    case (mc[6:0])
      7'b0000000: r = 8'h00;
      7'b1111000: r = 8'hFF;
      7'b0011000: r = a;
      7'b0101000: r = b;
      7'b1100000: r = ~a;
      7'b1010000: r = ~b;
      7'b0110001: r = 8'((int'(a) + int'(b)) % 256);
      7'b1001010: r = 8'((int'(a) - int'(b) + 256) % 256);
      7'b1001100: r = 8'((int'(b) - int'(a) + 256) % 256);
      7'b0001000: r = a & b;
      7'b0111000: r = a | b;
      7'b1110000: r = ~(a & b);
      7'b0110000: r = a ^ b;
      7'b1001000: r = ~(a ^ b);
      default:    r = 8'h00;
    endcase
    case (mc[9:7])
      3'd0: model = r;
      3'd1: model = 8'(int'(r) / 2);
      3'd2: model = 8'(int'(r) / 4);
      3'd3: model = 8'(int'(r) / 8);
      3'd4: model = 8'((int'(r) * 2) % 256);
      3'd5: model = 8'((int'(r) * 4) % 256);
      3'd6: model = 8'((int'(r) * 8) % 256);
      default: model = 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: pix_out got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_mc(input logic [9:0] v);
    mc_we = 1'b1; mc_in = v; tick(); mc_we = 1'b0;
  endtask

  task automatic set_dly(input logic [1:0] v);
    dly_we = 1'b1; dly_in = v; tick(); dly_we = 1'b0;
  endtask

  task automatic set_b(input logic [7:0] v);
    b_en = 1'b1; cin = v; tick(); b_en = 1'b0;
  endtask

  task automatic apply(input string req, input logic [9:0] mc, input logic [7:0] a, input logic [7:0] b);
    set_mc(mc);
    pix_in = a; tick();
    check(req, pix_out, model(mc, a, b));
  endtask

  task automatic t_reset();
    check("R1 reset output", pix_out, 8'h00);
    pix_in = 8'h5A; tick();
    check("R1 default pass A, delay 0", pix_out, 8'h5A);
    set_mc(10'b0000101000);
    pix_in = 8'h11; tick();
    check("R1 B cleared", pix_out, 8'h00);
  endtask

  task automatic t_logic();
    logic [6:0] ops [11] = '{7'b0000000, 7'b1111000, 7'b0011000, 7'b0101000, 7'b1100000,
                             7'b1010000, 7'b0001000, 7'b0111000, 7'b1110000, 7'b0110000, 7'b1001000};
    set_b(8'h3C);
    for (int i = 0; i < 11; i++) apply("R3 logic A=A5 B=3C", {3'b000, ops[i]}, 8'hA5, 8'h3C);
    for (int i = 6; i < 11; i++) apply("R3 logic A=0F B=3C", {3'b000, ops[i]}, 8'h0F, 8'h3C);
  endtask

  task automatic t_arith();
    set_b(8'hC8);
    apply("R4 A+B wrap", 10'b0000110001, 8'h64, 8'hC8);
    apply("R4 A-B borrow", 10'b0001001010, 8'h10, 8'hC8);
    apply("R4 B-A", 10'b0001001100, 8'h10, 8'hC8);
    apply("R4 A-B", 10'b0001001010, 8'hF0, 8'hC8);
  endtask

  task automatic t_shift();
    for (int s = 0; s < 8; s++) apply("R5 shift of pass A", {3'(s), 7'b0011000}, 8'hB6, 8'hC8);
    apply("R5 shift applies to A+B", {3'b011, 7'b0110001}, 8'h64, 8'hC8);
    apply("R5 left shift of NOT B", {3'b101, 7'b1010000}, 8'h00, 8'hC8);
  endtask

  task automatic t_undef();
    apply("R6 unlisted 0000001", 10'b0000000001, 8'hFF, 8'hC8);
    apply("R6 unlisted 1010101", 10'b0001010101, 8'hFF, 8'hC8);
    apply("R6 unlisted 1111111", 10'b0001111111, 8'h77, 8'hC8);
  endtask

  task automatic t_bload();
    set_mc(10'b0000101000);
    set_b(8'h9D);
    pix_in = 8'h00; tick();
    check("R7 B loaded from cin", pix_out, 8'h9D);
    cin = 8'h42; tick();
    check("R7 B kept with enable low", pix_out, 8'h9D);
  endtask

  task automatic t_delay();
    logic [7:0] v [10];
    set_mc(10'b0000011000);
    for (int d = 1; d < 4; d++) begin
      set_dly(2'(d));
      frame_clr = 1'b1; tick(); frame_clr = 1'b0;
      for (int k = 0; k < 10; k++) begin
        v[k] = 8'(k * 37 + d + 1);
        pix_in = v[k]; tick();
        check($sformatf("R8 delay %0d step %0d", d, k), pix_out, (k >= d) ? v[k-d] : 8'h00);
      end
    end
    set_dly(2'd0);
    pix_in = 8'hE1; tick();
    check("R2 delay setting back to 0", pix_out, 8'hE1);
  endtask

  task automatic t_hold();
    set_mc(10'b0000011000);
    set_b(8'h3C);
    set_dly(2'd1);
    pix_in = 8'h21; tick();
    pix_in = 8'h22; tick();
    check("R8 delay 1 before hold", pix_out, 8'h21);
    hold = 1'b1; b_en = 1'b1; cin = 8'hFF;
    pix_in = 8'h99; tick();
    check("R9 output frozen", pix_out, 8'h21);
    mc_we = 1'b1; mc_in = 10'b0001100000;
    pix_in = 8'h98; tick();
    mc_we = 1'b0;
    check("R9 output frozen 2", pix_out, 8'h21);
    hold = 1'b0; b_en = 1'b0;
    pix_in = 8'h23; tick();
    check("R2 microcode load during hold, R9 delay kept", pix_out, 8'hDD);
    set_mc(10'b0000101000);
    set_dly(2'd0);
    tick();
    check("R9 B not loaded during hold", pix_out, 8'h3C);
  endtask

  task automatic t_frame();
    set_mc(10'b0001100000);
    set_dly(2'd2);
    pix_in = 8'h0F; tick(); tick(); tick();
    check("R8 delay 2 NOT A", pix_out, 8'hF0);
    frame_clr = 1'b1; hold = 1'b1; tick();
    frame_clr = 1'b0; hold = 1'b0;
    check("R10 frame clear beats hold", pix_out, 8'h00);
    pix_in = 8'h55; tick();
    check("R10 delay line flushed, NOT A kept", pix_out, 8'hFF);
    tick();
    check("R10 delay setting kept", pix_out, 8'hFF);
    tick();
    check("R10 pixel after kept delay", pix_out, 8'hAA);
    set_dly(2'd0);
    set_mc(10'b0000101000);
    tick();
    check("R10 B kept", pix_out, 8'h3C);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_logic();
    t_arith();
    t_shift();
    t_undef();
    t_bload();
    t_delay();
    t_hold();
    t_frame();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule